// File: doc/BRIEF.md
# Bit-Serial Search Step Sequencer

This block performs one step of the single-wire bus ROM search. On a start pulse it asks the bit-slot layer for a read slot to get the identity bit, then a second read slot to get the complement bit. From those two bits and a branch direction supplied by the host, it either finds that no device answered, or picks a branch and sends that branch bit in one write slot. When the step ends it returns a 3-bit code that gives both sampled bits and the direction taken.

The host search loop calls this block once per ROM bit position and keeps the discrepancy bookkeeping itself. The bit-slot layer sits underneath and handles slot timing. Each slot is requested with a one-cycle request pulse, and the slot layer acknowledges it with a done strobe. A read done strobe also carries the sampled bit. A programmable cycle limit guards every slot. If the limit runs out, the step is abandoned and the abort is flagged.

Top module: `ow_search_step`

## Requirements
- R1: A step always uses slots in this order: read of the identity bit, read of the complement bit, then at most one write slot. The write request comes in the cycle right after the complement read's done strobe is accepted.
- R2: When both read bits are 1, no write slot is requested, and the step ends with code 3'b011 and error_o low.
- R3: When both read bits are 0, the host direction latched at start is written, and the code is 3'b100 for direction 1 or 3'b000 for direction 0.
- R4: When exactly one read bit is 1, the written bit equals the identity bit, and the code is 3'b101 (identity 1) or 3'b010 (identity 0).
- R5: Code bit 0 holds the identity bit and code bit 1 holds the complement bit. When a write took place, code bit 2 equals the bit driven on wr_slot_bit_o.
- R6: The block only advances on the done strobe of the slot kind it is waiting for. The strobe is accepted from the cycle after the request onward. A write done during a read, or any done while idle, has no effect.
- R7: If a slot's done strobe does not arrive within max(tmo_limit_i,1) cycles after its request, the step aborts. It then returns code 3'b011 with error_o high and requests no further slot.
- R8: A start pulse is taken only when the block is idle. A start during a step does not restart it and does not change the latched direction.
- R9: busy_o rises in the cycle after an accepted start. busy_o falls in the same cycle that done_o pulses high for exactly one cycle. result_o and error_o then hold until the next accepted start, and that start clears error_o.
- R10: After reset the block is idle, with no slot request, done_o low, result_o at 3'b000 and error_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start one search step (ignored while busy) |
| pref_dir_i | input | 1 | Host branch direction, used when both bits read 0 |
| tmo_limit_i | input | TMO_W | Slot completion limit in cycles (0 treated as 1) |
| rd_slot_req_o | output | 1 | One-cycle request for a read slot |
| rd_slot_done_i | input | 1 | Read slot completed strobe |
| rd_slot_bit_i | input | 1 | Bit sampled by the read slot, valid with its done strobe |
| wr_slot_req_o | output | 1 | One-cycle request for a write slot |
| wr_slot_bit_o | output | 1 | Bit to send in the write slot |
| wr_slot_done_i | input | 1 | Write slot completed strobe |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle end-of-step pulse |
| result_o | output | 3 | Step code: {direction, complement, identity} |
| error_o | output | 1 | Last step aborted on a slot timeout |

## Verification
The assertions assume that tmo_limit_i does not change during a step. They also assume that done strobes are single-cycle pulses that follow a request, so a done strobe never lands in the same cycle as its request. The bench keeps the limit fixed at eight cycles. Its slot model raises each done strobe exactly one to eight cycles after the matching request was seen. Stray strobes of the wrong kind and extra start pulses are injected only into wait cycles that lie strictly between a request and its answer.

// File: rtl/ow_step_pkg.sv
package ow_step_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_RD_ID  = 2'd1,
      ST_RD_CMP = 2'd2,
      ST_WR     = 2'd3
   } step_state_e;

   localparam logic [2:0] CODE_ABSENT = 3'b011;

   typedef struct packed {
      logic       do_write;
      logic       dir;
      logic [2:0] code;
   } branch_t;

endpackage

// File: rtl/ow_branch_decide.sv
module ow_branch_decide
   import ow_step_pkg::*;
(
   input  logic    id_i,
   input  logic    cmp_i,
   input  logic    pref_i,
   output branch_t br_o
);

   always_comb begin
      br_o.code[0] = id_i;
      br_o.code[1] = cmp_i;
      unique case ({id_i, cmp_i})
         2'b11: begin
            br_o.do_write = 1'b0;
            br_o.dir      = 1'b0;
         end
         2'b00: begin
            br_o.do_write = 1'b1;
            br_o.dir      = pref_i;
         end
         default: begin
            br_o.do_write = 1'b1;
            br_o.dir      = id_i;
         end
      endcase
      br_o.code[2] = br_o.do_write & br_o.dir;
   end

endmodule

// File: rtl/ow_slot_watchdog.sv
module ow_slot_watchdog #(
   parameter int TMO_W  = 16,
   parameter bit TMO_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             arm_i,
   input  logic             wait_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic             expire_o
);

   generate
      if (TMO_W < 2) begin : g_bad_width
         $error("ow_slot_watchdog: TMO_W must be at least 2");
      end

      if (TMO_EN) begin : g_wd
         logic [TMO_W-1:0] cnt_q;
         logic [TMO_W-1:0] eff_lim;

         assign eff_lim  = (limit_i == '0) ? TMO_W'(1) : limit_i;
         assign expire_o = wait_i && (cnt_q >= eff_lim);

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
            end else if (arm_i) begin
               cnt_q <= TMO_W'(1);
            end else if (wait_i && (cnt_q < eff_lim)) begin
               cnt_q <= cnt_q + TMO_W'(1);
            end
         end

         AST_WD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cnt_q <= eff_lim); // R7
      end else begin : g_nowd
         assign expire_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ow_step_fsm.sv
module ow_step_fsm
   import ow_step_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       start_i,
   input  logic       pref_dir_i,
   input  logic       rd_done_i,
   input  logic       rd_bit_i,
   input  logic       wr_done_i,
   input  logic       expire_i,
   input  branch_t    br_i,
   output logic       id_o,
   output logic       pref_o,
   output logic       arm_o,
   output logic       wait_o,
   output logic       rd_req_o,
   output logic       wr_req_o,
   output logic       wr_bit_o,
   output logic       busy_o,
   output logic       done_o,
   output logic [2:0] result_o,
   output logic       error_o
);

   step_state_e state_q;
   logic        issued_q;
   logic        id_q;
   logic        pref_q;
   logic        dir_q;
   logic [2:0]  pend_q;
   logic [2:0]  res_q;
   logic        err_q;
   logic        done_q;
   logic        in_slot;
   logic        slot_done;

   assign in_slot   = (state_q != ST_IDLE);
   assign slot_done = (state_q == ST_WR) ? wr_done_i : rd_done_i;
   assign arm_o     = in_slot && !issued_q;
   assign wait_o    = in_slot && issued_q && !slot_done;
   assign rd_req_o  = ((state_q == ST_RD_ID) || (state_q == ST_RD_CMP)) && !issued_q;
   assign wr_req_o  = (state_q == ST_WR) && !issued_q;
   assign wr_bit_o  = dir_q;
   assign busy_o    = in_slot;
   assign done_o    = done_q;
   assign result_o  = res_q;
   assign error_o   = err_q;
   assign id_o      = id_q;
   assign pref_o    = pref_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         issued_q <= 1'b0;
         id_q     <= 1'b0;
         pref_q   <= 1'b0;
         dir_q    <= 1'b0;
         pend_q   <= '0;
         res_q    <= '0;
         err_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q  <= ST_RD_ID;
                  issued_q <= 1'b0;
                  pref_q   <= pref_dir_i;
                  err_q    <= 1'b0;
               end
            end
            ST_RD_ID: begin
               if (!issued_q) begin
                  issued_q <= 1'b1;
               end else if (rd_done_i) begin
                  id_q     <= rd_bit_i;
                  state_q  <= ST_RD_CMP;
                  issued_q <= 1'b0;
               end else if (expire_i) begin
                  state_q <= ST_IDLE;
                  res_q   <= CODE_ABSENT;
                  err_q   <= 1'b1;
                  done_q  <= 1'b1;
               end
            end
            ST_RD_CMP: begin
               if (!issued_q) begin
                  issued_q <= 1'b1;
               end else if (rd_done_i) begin
                  issued_q <= 1'b0;
                  if (br_i.do_write) begin
                     state_q <= ST_WR;
                     dir_q   <= br_i.dir;
                     pend_q  <= br_i.code;
                  end else begin
                     state_q <= ST_IDLE;
                     res_q   <= br_i.code;
                     done_q  <= 1'b1;
                  end
               end else if (expire_i) begin
                  state_q <= ST_IDLE;
                  res_q   <= CODE_ABSENT;
                  err_q   <= 1'b1;
                  done_q  <= 1'b1;
               end
            end
            ST_WR: begin
               if (!issued_q) begin
                  issued_q <= 1'b1;
               end else if (wr_done_i) begin
                  state_q <= ST_IDLE;
                  res_q   <= pend_q;
                  done_q  <= 1'b1;
               end else if (expire_i) begin
                  state_q <= ST_IDLE;
                  res_q   <= CODE_ABSENT;
                  err_q   <= 1'b1;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_req_o |-> $past(rd_done_i)); // R1

   AST_ABSENT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_RD_CMP) && issued_q && rd_done_i && id_q && rd_bit_i
      |=> !wr_req_o && done_o && (result_o == CODE_ABSENT)); // R2

   AST_DIR_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && !error_o && (result_o[1:0] != 2'b11) |-> result_o[2] == wr_bit_o); // R5

   AST_ABORT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && error_o |-> result_o == CODE_ABSENT); // R7

   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R9

   AST_BUSY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> done_o); // R9

   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o && !start_i |=> $stable(result_o) && $stable(error_o)); // R9

   AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({rd_req_o, wr_req_o, done_o})); // R1

endmodule

// File: rtl/ow_search_step.sv
module ow_search_step
   import ow_step_pkg::*;
#(
   parameter int TMO_W  = 16,
   parameter bit TMO_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             pref_dir_i,
   input  logic [TMO_W-1:0] tmo_limit_i,
   output logic             rd_slot_req_o,
   input  logic             rd_slot_done_i,
   input  logic             rd_slot_bit_i,
   output logic             wr_slot_req_o,
   output logic             wr_slot_bit_o,
   input  logic             wr_slot_done_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [2:0]       result_o,
   output logic             error_o
);

   generate
      if (TMO_W < 2 || TMO_W > 32) begin : g_bad_cfg
         $error("ow_search_step: TMO_W must lie in 2..32");
      end
   endgenerate

   branch_t br;
   logic    id_q;
   logic    pref_q;
   logic    arm;
   logic    waiting;
   logic    expire;

   ow_branch_decide u_decide (
      .id_i   (id_q),
      .cmp_i  (rd_slot_bit_i),
      .pref_i (pref_q),
      .br_o   (br)
   );

   ow_slot_watchdog #(
      .TMO_W  (TMO_W),
      .TMO_EN (TMO_EN)
   ) u_wd (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .arm_i    (arm),
      .wait_i   (waiting),
      .limit_i  (tmo_limit_i),
      .expire_o (expire)
   );

   ow_step_fsm u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .pref_dir_i (pref_dir_i),
      .rd_done_i  (rd_slot_done_i),
      .rd_bit_i   (rd_slot_bit_i),
      .wr_done_i  (wr_slot_done_i),
      .expire_i   (expire),
      .br_i       (br),
      .id_o       (id_q),
      .pref_o     (pref_q),
      .arm_o      (arm),
      .wait_o     (waiting),
      .rd_req_o   (rd_slot_req_o),
      .wr_req_o   (wr_slot_req_o),
      .wr_bit_o   (wr_slot_bit_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .result_o   (result_o),
      .error_o    (error_o)
   );

   AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o && start_i |=> busy_o && rd_slot_req_o); // R8

endmodule

// File: tb/ow_search_step_tb_top.sv
module ow_search_step_tb_top;

   localparam int TW  = 8;
   localparam int LIM = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          pref = 1'b0;
   logic [TW-1:0] lim = TW'(LIM);
   logic          rd_req, rd_done = 1'b0, rd_bit = 1'b0;
   logic          wr_req, wr_bit, wr_done = 1'b0;
   logic          busy, done;
   logic [2:0]    result;
   logic          error;

   int checks = 0;
   int fails  = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;

   always #4 clk = ~clk;

   ow_search_step #(.TMO_W(TW), .TMO_EN(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pref_dir_i(pref),
      .tmo_limit_i(lim), .rd_slot_req_o(rd_req), .rd_slot_done_i(rd_done),
      .rd_slot_bit_i(rd_bit), .wr_slot_req_o(wr_req), .wr_slot_bit_o(wr_bit),
      .wr_slot_done_i(wr_done), .busy_o(busy), .done_o(done),
      .result_o(result), .error_o(error)
   );

   always @(posedge clk) begin
      if (rd_req) rd_cnt <= rd_cnt + 1;
      if (wr_req) wr_cnt <= wr_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_code(input bit id, input bit cmp, input bit pd);
      if (id && cmp)        return 3'b011;
      else if (!id && !cmp) return {pd, 2'b00};
      else                  return {id, cmp, id};
   endfunction

   // wait (from the current negedge) until the chosen request is seen
   task automatic wait_req(input bit want_wr, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 20; i++) begin
         if (want_wr ? wr_req : rd_req) begin
            seen = 1'b1;
            break;
         end
         @(negedge clk);
      end
   endtask

   // serve one slot: latency lat cycles after the request, optional noise
   task automatic serve(input bit is_wr, input bit b, input int lat, input bit drop,
                        input bit noise, input bit restart, input string req);
      bit seen;
      wait_req(is_wr, seen);
      chk(seen, req, seen, 1);
      if (!seen || drop) return;
      for (int i = 0; i < lat; i++) begin
         @(negedge clk);
         start   = 1'b0;
         wr_done = 1'b0;
         rd_done = 1'b0;
         if (i < lat - 1) begin
            if (noise) begin
               if (is_wr) rd_done = 1'b1; else wr_done = 1'b1;
            end
            if (restart && i == 0) begin
               start = 1'b1;
               pref  = ~pref;
            end
         end
      end
      if (is_wr) wr_done = 1'b1;
      else begin
         rd_done = 1'b1;
         rd_bit  = b;
      end
      @(negedge clk);
      rd_done = 1'b0;
      wr_done = 1'b0;
      start   = 1'b0;
   endtask

   // drop: 0 none, 1 identity read, 2 complement read, 3 write slot
   task automatic run_step(input bit id, input bit cmp, input bit pd,
                           input int l1, input int l2, input int l3,
                           input int drop, input bit noise, input bit restart);
      int  r0, w0, er, ew;
      bit  want_wr, got;
      logic [2:0] ec;
      r0 = rd_cnt;
      w0 = wr_cnt;
      want_wr = !(id && cmp);
      @(negedge clk);
      start = 1'b1;
      pref  = pd;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9 busy after start", busy, 1);
      chk(error == 1'b0, "R9 error cleared at start", error, 0);
      serve(1'b0, id, l1, drop == 1, noise, restart, "R1 identity read request");
      if (drop != 1) serve(1'b0, cmp, l2, drop == 2, noise, 1'b0, "R1 complement read request");
      if (drop == 0 || drop == 3) begin
         if (want_wr) begin
            chk(wr_req == 1'b1, "R1 write request follows complement read", wr_req, 1);
            chk(wr_bit == (id ? 1'b1 : (cmp ? 1'b0 : pd)), "R3 R4 written bit", wr_bit,
                id ? 1 : (cmp ? 0 : int'(pd)));
            serve(1'b1, 1'b0, l3, drop == 3, 1'b0, 1'b0, "R1 write request");
         end
      end
      got = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (done) begin
            got = 1'b1;
            break;
         end
         @(negedge clk);
      end
      chk(got, "R9 done pulse", got, 1);
      ec = (drop != 0) ? 3'b011 : exp_code(id, cmp, pd);
      chk(result == ec, (drop != 0) ? "R7 abort code" :
          (id && cmp) ? "R2 absent code" : (id ^ cmp) ? "R4 R5 single code" : "R3 R5 conflict code",
          result, ec);
      chk(error == (drop != 0), "R7 error flag", error, int'(drop != 0));
      chk(busy == 1'b0, "R9 busy low with done", busy, 0);
      er = (drop == 1) ? 1 : 2;
      ew = (drop == 1 || drop == 2 || !want_wr) ? 0 : 1;
      @(negedge clk);
      chk(done == 1'b0, "R9 done single cycle", done, 0);
      chk(result == ec, "R9 result held", result, ec);
      repeat (3) @(negedge clk);
      chk(rd_cnt - r0 == er, restart ? "R8 read slot count" : "R1 read slot count",
          rd_cnt - r0, er);
      chk(wr_cnt - w0 == ew, (id && cmp) ? "R2 no write slot" : "R1 write slot count",
          wr_cnt - w0, ew);
      chk(busy == 1'b0 && result == ec, "R8 R9 idle and held", result, ec);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [2:0] hold;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(busy == 0 && rd_req == 0 && wr_req == 0 && done == 0, "R10 idle after reset",
          {busy, rd_req, wr_req, done}, 0);
      chk(result == 3'b000 && error == 0, "R10 result after reset", {error, result}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: every bit pair with both directions
      for (int k = 0; k < 8; k++)
         run_step(k[0], k[1], k[2], 1 + k % 3, 2, 1, 0, 1'b0, 1'b0);

      // R6: stray strobes while idle
      hold = result;
      rd_done = 1'b1; rd_bit = 1'b1; wr_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0; wr_done = 1'b0;
      @(negedge clk);
      chk(busy == 0 && result == hold && done == 0, "R6 idle strobes ignored", result, hold);

      // R6: wrong-kind strobes during waits
      run_step(1'b0, 1'b1, 1'b1, 4, 5, 3, 0, 1'b1, 1'b0);
      run_step(1'b0, 1'b0, 1'b1, 3, 3, 4, 0, 1'b1, 1'b0);

      // R8: start during a step is ignored
      run_step(1'b0, 1'b0, 1'b1, 4, 2, 2, 0, 1'b0, 1'b1);
      run_step(1'b0, 1'b0, 1'b0, 5, 1, 1, 0, 1'b0, 1'b1);

      // R7: timeout in each slot, and latency at the limit
      run_step(1'b1, 1'b0, 1'b0, 1, 1, 1, 1, 1'b0, 1'b0);
      run_step(1'b1, 1'b0, 1'b0, 2, 1, 1, 2, 1'b0, 1'b0);
      run_step(1'b0, 1'b0, 1'b1, 2, 2, 1, 3, 1'b0, 1'b0);
      run_step(1'b1, 1'b0, 1'b1, LIM, LIM, LIM, 0, 1'b0, 1'b0);

      // random mix
      for (int n = 0; n < 200; n++) begin
         bit a, b, p, nz, rs;
         int d;
         a  = 1'($urandom);
         b  = 1'($urandom);
         p  = 1'($urandom);
         nz = ($urandom % 4) == 0;
         rs = ($urandom % 5) == 0;
         d  = (($urandom % 10) == 0) ? 1 + int'($urandom % 3) : 0;
         if (d == 3 && a && b) d = 2;
         run_step(a, b, p, 1 + int'($urandom % LIM), 1 + int'($urandom % LIM),
                  1 + int'($urandom % LIM), d, nz, rs);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule